// File: doc/BRIEF.md
# Transmit Source-Address Inserter

This stage sits in a 4-bit transmit nibble path and writes the station's own 48-bit hardware address into each outgoing Ethernet frame. Software then supplies only the destination address, the EtherType and the payload. In insert mode the first twelve nibbles (the six destination octets) pass through unchanged. The twelve nibbles of the station address follow. Every nibble after that comes out twelve strobes later than it arrived. In bypass mode the frame goes through untouched, and software must already have placed the source address in the buffer.

The path advances only on clock edges where the strobe `ce` is high, so the same stage works whether the nibble rate equals the clock or is a fraction of it. The stream has no ready signal and no back-pressure. It runs at line rate: on every strobe the downstream stage must take the output nibble, and the upstream stage must offer its next nibble. A frame is the run of strobes over which `in_valid` stays high. Frames are framed by `in_valid` alone. A `cancel` pulse drops the frame in progress.

Top module: `srcaddr_inserter`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `out_valid` is 0 and `out_nib` is 0, whatever the inputs do.
- R2: Apart from `rst` and `cancel`, state and outputs change only on clock edges where `ce` is 1. Between strobes `out_valid` and `out_nib` hold their values.
- R3: In insert mode, input nibbles 0..11 of a frame leave unchanged. Each one appears on the output right after the strobe edge that accepted it.
- R4: In insert mode, output nibbles 12..23 are the station address, octet `src_addr[47:40]` first. Within each octet, bits [3:0] come out before bits [7:4].
- R5: In insert mode, input nibble k (k >= 12) leaves as output nibble k+12. `out_valid` falls on the strobe after the last such nibble, so a frame of L input nibbles gives L+12 output nibbles.
- R6: In bypass mode, each input nibble appears unchanged right after its accepting strobe. The output frame has the same length as the input frame.
- R7: The mode is set by `enable` (1 = insert) at the strobe that accepts a frame's first nibble. Changes to `enable` later in that frame have no effect on it.
- R8: `cancel` acts on any clock edge, with or without a strobe. At the next sample `out_valid` is 0, and it stays 0 until a new frame is offered. The next frame is handled normally.
- R9: In insert mode, once `in_valid` has fallen, further input is ignored until `out_valid` has dropped. Nibbles offered during the drain never reach the output.
- R10: `out_nib` is 0 whenever `out_valid` is 0.
- R11: In insert mode, a frame whose `in_valid` falls within its first twelve nibbles is abandoned. Only the nibbles received reach the output, no address is emitted, and `out_valid` falls on that strobe.
- R12: An insert-mode frame of exactly twelve nibbles gives the twelve destination nibbles and then the twelve address nibbles: 24 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Nibble-time strobe; the stream advances only when high |
| enable | input | 1 | 1 = insert the station address, 0 = bypass; sampled at frame start |
| cancel | input | 1 | Drops the frame in progress |
| src_addr | input | 48 | Station hardware address; held stable while frames are sent |
| in_valid | input | 1 | Input nibble present |
| in_nib | input | 4 | Input nibble |
| out_valid | output | 1 | Output nibble present |
| out_nib | output | 4 | Output nibble |

## Verification
On every cycle the assertions check four things: the outputs hold between strobes, a cancel clears the output at the next edge, the nibble is zero while the output is idle, and each nibble in the address window of an insert-mode frame matches the address port at its position. The bench scenarios cover the whole-frame behaviour: the exact twelve-strobe delay of the tail, the total frame length, bypass pass-through, the mode staying fixed within a frame, abandoned short frames, the exact-minimum frame, and recovery after a cancel. They also show that input offered during the drain is ignored, which needs a complete frame comparison to observe.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BYP  = 3'd1,
    PH_DST  = 3'd2,
    PH_INS  = 3'd3,
    PH_FWD  = 3'd4
  } phase_e;
endpackage

// File: rtl/sai_nibble_line.sv
module sai_nibble_line #(
  parameter int W     = 4,
  parameter int DEPTH = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         flush,
  input  logic         push_v,
  input  logic [W-1:0] push_d,
  output logic         tap_v,
  output logic [W-1:0] tap_d
);
  logic         stg_v [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || flush) begin
            stg_v[i] <= 1'b0;
            stg_d[i] <= '0;
          end else if (ce) begin
            stg_v[i] <= push_v;
            stg_d[i] <= push_d;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst || flush) begin
            stg_v[i] <= 1'b0;
            stg_d[i] <= '0;
          end else if (ce) begin
            stg_v[i] <= stg_v[i-1];
            stg_d[i] <= stg_d[i-1];
          end
        end
      end
    end
  endgenerate

  assign tap_v = stg_v[DEPTH-1];
  assign tap_d = stg_d[DEPTH-1];
endmodule

// File: rtl/sai_addr_nibbles.sv
module sai_addr_nibbles #(
  parameter int ADDR_OCTETS = 6,
  parameter int IDX_W       = 4
) (
  input  logic [ADDR_OCTETS*8-1:0] addr,
  input  logic [IDX_W-1:0]         idx,
  output logic [3:0]               nib
);
  localparam int NIBS = ADDR_OCTETS * 2;

  logic [3:0] tbl [NIBS];

  // Octet order: most significant first; inside an octet, low half first.
  generate
    for (genvar j = 0; j < NIBS; j++) begin : g_nib
      localparam int OCT = j / 2;
      localparam int LSB = (ADDR_OCTETS - 1 - OCT) * 8 + (j % 2) * 4;
      assign tbl[j] = addr[LSB +: 4];
    end
  endgenerate

  always_comb begin
    nib = '0;
    for (int j = 0; j < NIBS; j++) begin
      if (idx == IDX_W'(j)) nib = tbl[j];
    end
  end
endmodule

// File: rtl/sai_phase_ctl.sv
module sai_phase_ctl
  import sai_pkg::*;
#(
  parameter int DST_NIBS = 12,
  parameter int INS_NIBS = 12,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             cancel,
  input  logic             enable,
  input  logic             in_valid,
  input  logic             tap_valid,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             push_v
);
  localparam logic [CNT_W-1:0] DST_LAST = CNT_W'(DST_NIBS - 1);
  localparam logic [CNT_W-1:0] INS_LAST = CNT_W'(INS_NIBS - 1);
  localparam bool_one_dst = (DST_NIBS == 1);

  logic in_open;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      in_open <= 1'b0;
    end else if (ce) begin
      unique case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            in_open <= 1'b1;
            if (!enable) begin
              phase <= PH_BYP;
              cnt   <= '0;
            end else if (bool_one_dst) begin
              phase <= PH_INS;
              cnt   <= '0;
            end else begin
              phase <= PH_DST;
              cnt   <= CNT_W'(1);
            end
          end
        end
        PH_BYP: begin
          if (!in_valid) begin
            phase   <= PH_IDLE;
            in_open <= 1'b0;
          end
        end
        PH_DST: begin
          if (!in_valid) begin
            phase   <= PH_IDLE;
            in_open <= 1'b0;
            cnt     <= '0;
          end else if (cnt == DST_LAST) begin
            phase <= PH_INS;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_INS: begin
          in_open <= in_open && in_valid;
          if (cnt == INS_LAST) begin
            phase <= PH_FWD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FWD: begin
          in_open <= in_open && in_valid;
          if (!tap_valid) begin
            phase   <= PH_IDLE;
            in_open <= 1'b0;
          end
        end
        default: begin
          phase   <= PH_IDLE;
          cnt     <= '0;
          in_open <= 1'b0;
        end
      endcase
    end
  end

  // Which input nibbles enter the delay line.
  always_comb begin
    unique case (phase)
      PH_IDLE:        push_v = in_valid && enable;
      PH_DST:         push_v = in_valid;
      PH_INS, PH_FWD: push_v = in_valid && in_open;
      default:        push_v = 1'b0;
    endcase
  end
endmodule

// File: rtl/srcaddr_inserter.sv
module srcaddr_inserter
  import sai_pkg::*;
#(
  parameter int ADDR_OCTETS = 6,
  parameter int DST_OCTETS  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     enable,
  input  logic                     cancel,
  input  logic [ADDR_OCTETS*8-1:0] src_addr,
  input  logic                     in_valid,
  input  logic [3:0]               in_nib,
  output logic                     out_valid,
  output logic [3:0]               out_nib
);
  localparam int DST_NIBS = DST_OCTETS * 2;
  localparam int INS_NIBS = ADDR_OCTETS * 2;
  localparam int MAX_NIBS = (DST_NIBS > INS_NIBS) ? DST_NIBS : INS_NIBS;
  localparam int CNT_W    = $clog2(MAX_NIBS + 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               push_v;
  logic               tap_v;
  logic [NIB_W-1:0]   tap_d;
  logic [NIB_W-1:0]   ins_nib;

  sai_phase_ctl #(
    .DST_NIBS (DST_NIBS),
    .INS_NIBS (INS_NIBS),
    .CNT_W    (CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .cancel    (cancel),
    .enable    (enable),
    .in_valid  (in_valid),
    .tap_valid (tap_v),
    .phase     (phase),
    .cnt       (cnt),
    .push_v    (push_v)
  );

  sai_nibble_line #(
    .W     (NIB_W),
    .DEPTH (INS_NIBS)
  ) u_line (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .flush  (cancel),
    .push_v (push_v),
    .push_d (in_nib),
    .tap_v  (tap_v),
    .tap_d  (tap_d)
  );

  sai_addr_nibbles #(
    .ADDR_OCTETS (ADDR_OCTETS),
    .IDX_W       (CNT_W)
  ) u_addr (
    .addr (src_addr),
    .idx  (cnt),
    .nib  (ins_nib)
  );

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      out_valid <= 1'b0;
      out_nib   <= '0;
    end else if (ce) begin
      unique case (phase)
        PH_INS: begin
          out_valid <= 1'b1;
          out_nib   <= ins_nib;
        end
        PH_FWD: begin
          out_valid <= tap_v;
          out_nib   <= tap_v ? tap_d : '0;
        end
        default: begin
          out_valid <= in_valid;
          out_nib   <= in_valid ? in_nib : '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sai_checker.sv
module sai_checker #(
  parameter int ADDR_OCTETS = 6,
  parameter int DST_OCTETS  = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ce,
  input logic                     enable,
  input logic                     cancel,
  input logic [ADDR_OCTETS*8-1:0] src_addr,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic [3:0]               out_nib
);
  localparam int ADDR_W   = ADDR_OCTETS * 8;
  localparam int DST_NIBS = DST_OCTETS * 2;
  localparam int INS_NIBS = ADDR_OCTETS * 2;

  logic       mode_ins;
  logic [6:0] ocnt;
  logic       in_window;
  logic [3:0] want_nib;
  logic [ADDR_W-1:0] shifted;

  // Independent frame tracker seen only from the ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ins <= 1'b0;
      ocnt     <= '0;
    end else if (ce && !cancel) begin
      if (!out_valid && in_valid) begin
        mode_ins <= enable;
        ocnt     <= '0;
      end else if (out_valid && ocnt != 7'h7f) begin
        ocnt <= ocnt + 7'd1;
      end
    end
  end

  always_comb begin
    int j;
    int sh;
    j         = int'(ocnt) - DST_NIBS;
    in_window = (j >= 0) && (j < INS_NIBS);
    sh        = 0;
    if (in_window) sh = ADDR_W - 8 * (j / 2 + 1) + 4 * (j % 2);
    shifted   = src_addr >> sh;
    want_nib  = shifted[3:0];
  end

  // R2
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce && !cancel) |=> ($stable(out_valid) && $stable(out_nib)));

  // R8
  cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !out_valid);

  // R10
  idle_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_nib == 4'h0));

  // R4
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_ins && in_window) |-> (out_nib == want_nib));
endmodule

bind srcaddr_inserter sai_checker #(
  .ADDR_OCTETS (ADDR_OCTETS),
  .DST_OCTETS  (DST_OCTETS)
) u_sai_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .enable    (enable),
  .cancel    (cancel),
  .src_addr  (src_addr),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_nib   (out_nib)
);

// File: tb/srcaddr_inserter_test.sv
module srcaddr_inserter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        enable = 1'b0;
  logic        cancel = 1'b0;
  logic [47:0] src_addr = 48'h0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_nib = 4'h0;
  logic        out_valid;
  logic [3:0]  out_nib;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [3:0] dat   [0:127];
  logic [3:0] exp_q [0:255];
  logic [3:0] got_q [0:255];
  int nexp, ngot, unstable, zero_bad;
  bit first_valid, timed_out;

  srcaddr_inserter uut (
    .clk (clk), .rst (rst), .ce (ce), .enable (enable), .cancel (cancel),
    .src_addr (src_addr), .in_valid (in_valid), .in_nib (in_nib),
    .out_valid (out_valid), .out_nib (out_nib)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] addr_nib(input int j);
    logic [7:0] oct;
    oct = src_addr[8*(5 - j/2) +: 8];
    return (j % 2 == 0) ? oct[3:0] : oct[7:4];
  endfunction

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ce = 1'b1; in_valid = 1'b0; in_nib = 4'h0; cancel = 1'b0;
    end
  endtask

  // Drives one frame, collects the output frame and builds the expected one.
  task automatic drive_frame(input bit en, input int len, input int div,
                             input int flip_at, input bit junk);
    int idx, post, step;
    bit prev_ce, seen, done, last_v;
    logic [3:0] last_n;
    for (int i = 0; i < len; i++) dat[i] = 4'((i * 5 + len + 3) & 15);
    nexp = 0;
    if (en && len >= 12) begin
      for (int i = 0; i < 12; i++) begin exp_q[nexp] = dat[i]; nexp++; end
      for (int j = 0; j < 12; j++) begin exp_q[nexp] = addr_nib(j); nexp++; end
      for (int i = 12; i < len; i++) begin exp_q[nexp] = dat[i]; nexp++; end
    end else begin
      for (int i = 0; i < len; i++) begin exp_q[nexp] = dat[i]; nexp++; end
    end
    ngot = 0; unstable = 0; zero_bad = 0; first_valid = 0; timed_out = 0;
    idx = 0; post = 0; step = 0; prev_ce = 0; seen = 0; done = 0;
    last_v = 0; last_n = 4'h0;
    enable = en;
    while (!done && step < 3000) begin
      @(negedge clk);
      if (out_valid == 1'b0 && out_nib != 4'h0) zero_bad++;
      if (prev_ce) begin
        if (!seen && out_valid) first_valid = (ngot == 0) && (step == 1);
        if (out_valid) begin
          seen = 1;
          if (ngot < 256) got_q[ngot] = out_nib;
          ngot++;
        end else if (seen) done = 1;
        last_v = out_valid; last_n = out_nib;
      end else if (step > 0 && (out_valid !== last_v || out_nib !== last_n)) begin
        unstable++;
      end
      prev_ce = (step % div == 0);
      ce = prev_ce;
      if (prev_ce) begin
        if (idx < len) begin
          in_valid = 1'b1; in_nib = dat[idx]; idx++;
        end else begin
          post++;
          if (junk && post >= 3 && post <= 6) begin
            in_valid = 1'b1; in_nib = 4'hF;
          end else begin
            in_valid = 1'b0; in_nib = 4'h0;
          end
        end
      end
      if (flip_at >= 0 && idx == flip_at) enable = !en;
      step++;
    end
    if (!done) timed_out = 1;
    enable = en;
    idle_cycles(4);
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    chk(!timed_out, {tag, " frame end"}, 0, 1);
    chk(ngot == nexp, {tag, " length"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    if (bad >= 0) chk(0, {tag, " nibble"}, int'(got_q[bad]), int'(exp_q[bad]));
    else chk(1, {tag, " nibble"}, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    ce = 1'b1; in_valid = 1'b1; in_nib = 4'hA; enable = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_nib == 4'h0, "R1 nibble in reset", int'(out_nib), 0);
    in_valid = 1'b0; in_nib = 4'h0; ce = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_nib == 4'h0, "R1 nibble after reset", int'(out_nib), 0);
  endtask

  task automatic t_insert();
    src_addr = 48'h0255_3A7C_E19B;
    drive_frame(1, 40, 1, -1, 0);
    compare("R3 R4 R5 insert");
    chk(first_valid, "R3 first nibble latency", int'(first_valid), 1);
    chk(zero_bad == 0, "R10 idle nibble", zero_bad, 0);
  endtask

  task automatic t_bypass();
    drive_frame(0, 30, 1, -1, 0);
    compare("R6 bypass");
  endtask

  task automatic t_strobe();
    src_addr = 48'hC4D1_0086_F25E;
    drive_frame(1, 34, 3, -1, 0);
    compare("R2 slow strobe");
    chk(unstable == 0, "R2 hold between strobes", unstable, 0);
  endtask

  task automatic t_mode_hold();
    drive_frame(1, 36, 1, 5, 0);
    compare("R7 insert kept");
    drive_frame(0, 20, 1, 5, 0);
    compare("R7 bypass kept");
  endtask

  task automatic t_cancel();
    int bad;
    bad = 0;
    enable = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ce = 1'b1; in_valid = 1'b1; in_nib = 4'(i);
    end
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 frame live before cancel", int'(out_valid), 1);
    cancel = 1'b1; ce = 1'b0; in_valid = 1'b0; in_nib = 4'h0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid after cancel", int'(out_valid), 0);
    cancel = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      ce = 1'b1;
      if (out_valid) bad++;
    end
    chk(bad == 0, "R8 stays idle", bad, 0);
    drive_frame(1, 30, 1, -1, 0);
    compare("R8 recovery");
  endtask

  task automatic t_drain();
    drive_frame(1, 30, 1, -1, 1);
    compare("R9 drain ignores input");
  endtask

  task automatic t_runt();
    drive_frame(1, 8, 1, -1, 0);
    compare("R11 short frame");
    chk(zero_bad == 0, "R10 idle nibble short", zero_bad, 0);
  endtask

  task automatic t_min();
    drive_frame(1, 12, 1, -1, 0);
    compare("R12 minimum frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_insert();
    t_bypass();
    t_strobe();
    t_mode_hold();
    t_cancel();
    t_drain();
    t_runt();
    t_min();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule